// File: doc/BRIEF.md
# Wiregroup-to-Polar-Angle Converter

This block turns the wiregroup number carried by a chamber trigger primitive into an 8-bit polar angle. For chambers with wires perpendicular to the strips, the angle is a plain lookup: the wiregroup addresses a table of angles. For chambers whose wires are tilted, the angle also depends on where along the wire the hit lies. The block then takes a base angle from the wiregroup and adds a small 4-bit correction. That correction comes from a second table, addressed by the strip number together with the two top bits of the wiregroup.

A chamber can deliver one or two primitives per crossing. In tilted mode the block cannot tell which wiregroup belongs to which strip. It therefore pairs every wiregroup with every strip, so two primitives produce four angle candidates. Downstream logic chooses among these candidates. The three tables are loaded through a single write port. Table writes never hold off the datapath, which accepts a new input on every clock and returns results two clocks later.

Top module: `wgth_conv`

## Requirements
- R1: In normal mode (`in_tilt`=0), each output angle equals the normal table entry addressed by the full 7-bit wiregroup. No correction is added.
- R2: In tilted mode (`in_tilt`=1), an output angle is the tilted base table entry at wiregroup bits [5:0], plus the 4-bit correction table entry at address {wiregroup[5:4], strip[5:0]}. Wiregroup bit 6 is ignored.
- R3: The tilted-mode sum saturates at 255 and never wraps.
- R4: The four output lanes are ordered as follows: lane 0 is WG1 with strip 1, lane 1 is WG1 with strip 2, lane 2 is WG2 with strip 1, and lane 3 is WG2 with strip 2.
- R5: In normal mode, lane 0 is valid and lane 2 is valid when `in_two`=1. Lanes 1 and 3 are always invalid in this mode. Every invalid lane drives an angle of 0.
- R6: In tilted mode with `in_two`=0, only lane 0 is valid. With `in_two`=1, all four lanes are valid.
- R7: Outputs appear exactly 2 clocks after the input is sampled. A cycle without `in_valid` produces all-invalid outputs 2 clocks later.
- R8: A write with `cfg_we`=1 selects its table with `cfg_sel`: 0 is the normal table, 1 is the tilted base table and 2 is the correction table. The value 3 writes nothing. A written entry is used by inputs sampled from the next clock onward. An input sampled on the same edge as the write sees the old entry.
- R9: Inputs are accepted on every clock, including clocks that carry a table write, and results stream out back to back.
- R10: Reset clears all outputs to invalid and 0, and clears every table entry to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input primitive set present this clock |
| in_tilt | input | 1 | 1 = tilted-wire chamber, 0 = normal chamber |
| in_two | input | 1 | A second primitive is present |
| in_wg1 | input | 7 | Wiregroup of primitive 1 |
| in_wg2 | input | 7 | Wiregroup of primitive 2 |
| in_strip1 | input | 6 | Strip of primitive 1 |
| in_strip2 | input | 6 | Strip of primitive 2 |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | 2 | Target table of the write |
| cfg_addr | input | 8 | Table entry address; bits above the table's width are ignored |
| cfg_data | input | 8 | Entry value; the correction table keeps bits [3:0] |
| out_valid | output | 4 | Per-lane valid flag |
| out_theta | output | 32 | Four 8-bit angles, lane 0 in bits [7:0] |

## Verification
The bench drives base angles near the top of the range with the largest correction. It covers one sum that lands exactly on 255 and one that would exceed it. A wrapping adder would return small angles for these cases. It places a table write on the same clock as an input that reads that entry, and then reads the entry again on the next clock. A design with the write/read order reversed would return the new value one cycle early. It also checks that lanes 1 and 3 stay invalid in normal mode, that wiregroup bit 6 is ignored in tilted mode, and that a write with selector 3 leaves every table untouched. Finally, a long mixed stream with interleaved writes would expose any stall or lane mis-ordering.

// File: rtl/wgth_pkg.sv
package wgth_pkg;
  localparam int TH_W   = 8;  // angle width
  localparam int CORR_W = 4;  // tilt correction width
  localparam int NPRIM  = 2;  // primitives per chamber
  localparam int NLANE  = NPRIM * NPRIM;

  typedef enum logic [1:0] {
    TBL_NORM = 2'd0,
    TBL_TILT = 2'd1,
    TBL_CORR = 2'd2,
    TBL_NONE = 2'd3
  } tbl_sel_e;

  // Base plus correction, clamped at the top of the angle range.
  function automatic logic [TH_W-1:0] sat_add(input logic [TH_W-1:0] base,
                                               input logic [CORR_W-1:0] corr);
    logic [TH_W:0] sum;
    sum = {1'b0, base} + {{(TH_W+1-CORR_W){1'b0}}, corr};
    return sum[TH_W] ? {TH_W{1'b1}} : sum[TH_W-1:0];
  endfunction

  // Which lanes carry a meaningful angle for a given mode.
  function automatic logic [NLANE-1:0] lane_mask(input logic tilt, input logic two);
    logic [NLANE-1:0] m;
    for (int k = 0; k < NLANE; k++) begin
      if (tilt) m[k] = (k == 0) || two;
      else      m[k] = ((k % NPRIM) == 0) && ((k / NPRIM) == 0 || two);
    end
    return m;
  endfunction
endpackage

// File: rtl/wgth_table.sv
module wgth_table #(
  parameter int AW  = 7,
  parameter int DW  = 8,
  parameter int NRD = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [AW-1:0]            waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [NRD-1:0][AW-1:0]   raddr,
  output logic [NRD-1:0][DW-1:0]   rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rdata[r] = mem[raddr[r]];
  end
endmodule

// File: rtl/wgth_lane.sv
module wgth_lane import wgth_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [TH_W-1:0]   base,
  input  logic [CORR_W-1:0] corr,
  output logic              valid,
  output logic [TH_W-1:0]   theta
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      theta <= '0;
    end else begin
      valid <= en;
      theta <= en ? sat_add(base, corr) : '0;
    end
  end
endmodule

// File: rtl/wgth_conv.sv
module wgth_conv import wgth_pkg::*; #(
  parameter int WG_W    = 7,
  parameter int TWG_W   = 6,
  parameter int STRIP_W = 6,
  parameter int MSB_N   = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic                          in_tilt,
  input  logic                          in_two,
  input  logic [WG_W-1:0]               in_wg1,
  input  logic [WG_W-1:0]               in_wg2,
  input  logic [STRIP_W-1:0]            in_strip1,
  input  logic [STRIP_W-1:0]            in_strip2,
  input  logic                          cfg_we,
  input  logic [1:0]                    cfg_sel,
  input  logic [7:0]                    cfg_addr,
  input  logic [TH_W-1:0]               cfg_data,
  output logic [NLANE-1:0]              out_valid,
  output logic [NLANE-1:0][TH_W-1:0]    out_theta
);
  localparam int NORM_AW = WG_W;
  localparam int TILT_AW = TWG_W;
  localparam int CORR_AW = MSB_N + STRIP_W;

  logic [NPRIM-1:0][WG_W-1:0]    wg_in;
  logic [NPRIM-1:0][STRIP_W-1:0] st_in;
  assign wg_in = {in_wg2, in_wg1};
  assign st_in = {in_strip2, in_strip1};

  // table read ports
  logic [NPRIM-1:0][NORM_AW-1:0] nb_ra;
  logic [NPRIM-1:0][TH_W-1:0]    nb_rd;
  logic [NPRIM-1:0][TILT_AW-1:0] tb_ra;
  logic [NPRIM-1:0][TH_W-1:0]    tb_rd;
  logic [NLANE-1:0][CORR_AW-1:0] cr_ra;
  logic [NLANE-1:0][CORR_W-1:0]  cr_rd;

  for (genvar p = 0; p < NPRIM; p++) begin : g_prim
    assign nb_ra[p] = wg_in[p];
    assign tb_ra[p] = wg_in[p][TILT_AW-1:0];
  end

  for (genvar k = 0; k < NLANE; k++) begin : g_cra
    assign cr_ra[k] = {wg_in[k / NPRIM][TWG_W-1 -: MSB_N], st_in[k % NPRIM]};
  end

  // write decode
  logic we_norm, we_tilt, we_corr;
  assign we_norm = cfg_we && (cfg_sel == TBL_NORM);
  assign we_tilt = cfg_we && (cfg_sel == TBL_TILT);
  assign we_corr = cfg_we && (cfg_sel == TBL_CORR);

  wgth_table #(.AW(NORM_AW), .DW(TH_W), .NRD(NPRIM)) u_norm (
    .clk(clk), .rst_n(rst_n), .we(we_norm), .waddr(cfg_addr[NORM_AW-1:0]),
    .wdata(cfg_data), .raddr(nb_ra), .rdata(nb_rd));

  wgth_table #(.AW(TILT_AW), .DW(TH_W), .NRD(NPRIM)) u_tilt (
    .clk(clk), .rst_n(rst_n), .we(we_tilt), .waddr(cfg_addr[TILT_AW-1:0]),
    .wdata(cfg_data), .raddr(tb_ra), .rdata(tb_rd));

  wgth_table #(.AW(CORR_AW), .DW(CORR_W), .NRD(NLANE)) u_corr (
    .clk(clk), .rst_n(rst_n), .we(we_corr), .waddr(cfg_addr[CORR_AW-1:0]),
    .wdata(cfg_data[CORR_W-1:0]), .raddr(cr_ra), .rdata(cr_rd));

  // stage 1: lookup results per lane
  logic [NLANE-1:0][TH_W-1:0]   base_c;
  logic [NLANE-1:0][CORR_W-1:0] corr_c;

  for (genvar k = 0; k < NLANE; k++) begin : g_sel
    assign base_c[k] = in_tilt ? tb_rd[k / NPRIM] : nb_rd[k / NPRIM];
    assign corr_c[k] = in_tilt ? cr_rd[k] : '0;
  end

  logic                         s1_valid, s1_tilt, s1_two;
  logic [NLANE-1:0][TH_W-1:0]   s1_base;
  logic [NLANE-1:0][CORR_W-1:0] s1_corr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_tilt  <= 1'b0;
      s1_two   <= 1'b0;
      s1_base  <= '0;
      s1_corr  <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_tilt  <= in_tilt;
      s1_two   <= in_two;
      s1_base  <= base_c;
      s1_corr  <= corr_c;
    end
  end

  // stage 2: per-lane add and register
  logic [NLANE-1:0] lane_en;
  assign lane_en = s1_valid ? lane_mask(s1_tilt, s1_two) : '0;

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    wgth_lane u_lane (
      .clk(clk), .rst_n(rst_n), .en(lane_en[k]), .base(s1_base[k]),
      .corr(s1_corr[k]), .valid(out_valid[k]), .theta(out_theta[k]));
  end
endmodule

// File: rtl/wgth_conv_sva.sv
module wgth_conv_sva import wgth_pkg::*; (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          in_valid,
  input logic                          in_tilt,
  input logic                          in_two,
  input logic [NLANE-1:0]              out_valid,
  input logic [NLANE-1:0][TH_W-1:0]    out_theta,
  input logic [NLANE-1:0][TH_W-1:0]    s1_base,
  input logic [NLANE-1:0][CORR_W-1:0]  s1_corr
);
  logic [1:0] since;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since <= '0;
    else if (since != 2'd2) since <= since + 2'd1;
  end

  // R7: lane 0 follows the input valid two clocks later
  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (since == 2'd2) |-> (out_valid[0] == $past(in_valid, 2)));

  // R5: duplicated lanes stay off in normal mode
  p_dup_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (since == 2'd2 && out_valid[0] && !$past(in_tilt, 2))
      |-> (!out_valid[1] && !out_valid[3]));

  // R6: a single primitive yields a single valid lane
  p_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (since == 2'd2 && out_valid[0] && !$past(in_two, 2))
      |-> (out_valid[NLANE-1:1] == '0));

  for (genvar k = 0; k < NLANE; k++) begin : g_lane_chk
    // R3: the result never falls below the base it was built from
    p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (since != 2'd0 && out_valid[k]) |-> (out_theta[k] >= $past(s1_base[k])));

    // R3: an overflowing sum clamps to the top code
    p_clamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (since != 2'd0 && out_valid[k] &&
       ({1'b0, $past(s1_base[k])} + {5'd0, $past(s1_corr[k])}) > 9'd255)
        |-> (out_theta[k] == 8'hFF));

    // R5: a lane without valid carries a zero angle
    p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid[k] |-> (out_theta[k] == '0));
  end
endmodule

bind wgth_conv wgth_conv_sva u_sva (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tilt(in_tilt),
  .in_two(in_two), .out_valid(out_valid), .out_theta(out_theta),
  .s1_base(s1_base), .s1_corr(s1_corr));

// File: tb/wgth_conv_tb.sv
module wgth_conv_tb;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_tilt = 1'b0, in_two = 1'b0;
  logic [6:0] in_wg1 = '0, in_wg2 = '0;
  logic [5:0] in_strip1 = '0, in_strip2 = '0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [7:0] cfg_addr = '0, cfg_data = '0;
  logic [3:0] out_valid;
  logic [3:0][7:0] out_theta;

  wgth_conv u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tilt(in_tilt),
    .in_two(in_two), .in_wg1(in_wg1), .in_wg2(in_wg2),
    .in_strip1(in_strip1), .in_strip2(in_strip2), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .out_valid(out_valid), .out_theta(out_theta));

  always #(CLK_P / 2) clk = ~clk;

  typedef struct {
    int              due;
    logic [3:0]      vld;
    logic [3:0][7:0] th;
    string           req;
  } exp_t;

  exp_t q[$];
  int   nchk = 0;
  int   nfail = 0;
  int   cyc = 0;

  logic [7:0] sh_nb [128];
  logic [7:0] sh_tb [64];
  logic [3:0] sh_cr [256];

  task automatic check(input string req, input logic [3:0] av, input logic [31:0] at,
                       input logic [3:0] ev, input logic [31:0] et);
    nchk++;
    if (av !== ev || at !== et) begin
      nfail++;
      $display("FAIL %s: valid=%b theta=%h expected valid=%b theta=%h", req, av, at, ev, et);
    end
  endtask

  // bench model: angle of one lane
  function automatic logic [7:0] model_theta(input logic tilt, input logic [6:0] wg,
                                             input logic [5:0] st);
    int s;
    if (!tilt) return sh_nb[wg];
    s = int'(sh_tb[wg[5:0]]) + int'(sh_cr[{wg[5:4], st}]);
    return (s > 255) ? 8'd255 : s[7:0];
  endfunction

  task automatic go(input logic tilt, input logic two, input logic [6:0] w1,
                    input logic [6:0] w2, input logic [5:0] s1, input logic [5:0] s2,
                    input string req);
    exp_t e;
    logic [6:0] w;
    logic [5:0] s;
    in_valid = 1'b1; in_tilt = tilt; in_two = two;
    in_wg1 = w1; in_wg2 = w2; in_strip1 = s1; in_strip2 = s2;
    e.due = cyc + 2;
    e.req = req;
    e.th  = '0;
    for (int k = 0; k < 4; k++) begin
      w = (k < 2) ? w1 : w2;        // R4 lane order
      s = (k % 2 == 1) ? s2 : s1;
      if (tilt) e.vld[k] = (k == 0) || two;                       // R6
      else      e.vld[k] = (k == 0) || (k == 2 && two);           // R5
      if (e.vld[k]) e.th[k] = model_theta(tilt, w, s);
    end
    q.push_back(e);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] addr, input logic [7:0] data);
    cfg_we = 1'b1; cfg_sel = sel; cfg_addr = addr; cfg_data = data;
    case (sel)
      2'd0: sh_nb[addr[6:0]] = data;
      2'd1: sh_tb[addr[5:0]] = data;
      2'd2: sh_cr[addr] = data[3:0];
      default: ;
    endcase
  endtask

  task automatic tick;
    @(negedge clk);
    in_valid = 1'b0;
    cfg_we = 1'b0;
  endtask

  // monitor / scoreboard
  initial begin
    exp_t e;
    wait (rst_n === 1'b1);
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      if (q.size() > 0 && q[0].due == cyc) begin
        e = q.pop_front();
        check(e.req, out_valid, out_theta, e.vld, e.th);
      end else begin
        check("R7 idle", out_valid, out_theta, 4'b0, 32'h0);
      end
    end
  end

  // watchdog
  initial begin
    #(CLK_P * 200000);
    nfail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) sh_nb[i] = '0;
    for (int i = 0; i < 64; i++)  sh_tb[i] = '0;
    for (int i = 0; i < 256; i++) sh_cr[i] = '0;
    repeat (3) @(negedge clk);
    check("R10 reset", out_valid, out_theta, 4'b0, 32'h0);
    rst_n = 1'b1;

    // R10: tables read zero after reset
    go(1'b0, 1'b1, 7'd33, 7'd90, 6'd0, 6'd0, "R10 cleared table"); tick;
    go(1'b1, 1'b1, 7'd12, 7'd50, 6'd9, 6'd40, "R10 cleared table"); tick;

    // load every table
    for (int i = 0; i < 128; i++) begin wr(2'd0, i[7:0], 8'((i * 3 + 5) & 255)); tick; end
    for (int i = 0; i < 64; i++)  begin wr(2'd1, i[7:0], 8'(i * 4)); tick; end
    for (int i = 0; i < 256; i++) begin wr(2'd2, i[7:0], 8'((i * 7 + 3) & 15)); tick; end

    // R1 / R5: normal mode
    go(1'b0, 1'b0, 7'd10, 7'd0, 6'd3, 6'd7, "R1 normal single"); tick;
    go(1'b0, 1'b1, 7'd127, 7'd64, 6'd63, 6'd1, "R1 R5 normal pair"); tick;
    go(1'b0, 1'b1, 7'd0, 7'd100, 6'd20, 6'd21, "R5 normal dup lanes off"); tick;

    // R2 / R4 / R6: tilted mode, bit 6 of the wiregroup ignored
    go(1'b1, 1'b0, 7'h25, 7'h11, 6'd5, 6'd9, "R6 tilted single"); tick;
    go(1'b1, 1'b1, 7'h45, 7'h3A, 6'd5, 6'd60, "R2 R4 tilted pair"); tick;
    go(1'b1, 1'b1, 7'h05, 7'h7A, 6'd5, 6'd60, "R2 bit6 ignored"); tick;

    // R3: saturation
    wr(2'd1, 8'd63, 8'd250); tick;
    wr(2'd2, 8'd255, 8'd15); tick;
    go(1'b1, 1'b0, 7'd63, 7'd0, 6'd63, 6'd0, "R3 clamp 250+15"); tick;
    wr(2'd1, 8'd62, 8'd240); tick;
    wr(2'd2, 8'd193, 8'd15); tick;
    go(1'b1, 1'b1, 7'd62, 7'd63, 6'd1, 6'd63, "R3 exact 255 and clamp"); tick;
    wr(2'd1, 8'd1, 8'd255); tick;
    go(1'b1, 1'b1, 7'd1, 7'd1, 6'd0, 6'd2, "R3 full base"); tick;

    // R8: same-edge write sees old value, next edge sees new
    go(1'b0, 1'b0, 7'd20, 7'd0, 6'd0, 6'd0, "R8 same edge old");
    wr(2'd0, 8'd20, 8'hAA); tick;
    go(1'b0, 1'b0, 7'd20, 7'd0, 6'd0, 6'd0, "R8 next edge new"); tick;

    // R8: selector 3 writes nothing
    wr(2'd3, 8'd20, 8'h11); tick;
    go(1'b0, 1'b1, 7'd20, 7'd20, 6'd20, 6'd20, "R8 sel3 normal intact"); tick;
    go(1'b1, 1'b1, 7'd20, 7'd20, 6'd20, 6'd20, "R8 sel3 tilt intact"); tick;

    // R9: back-to-back stream with interleaved writes
    for (int i = 0; i < 24; i++) begin
      go(i[0], (i % 3) == 0, 7'((i * 5) & 127), 7'((i * 11) & 127),
         6'((i * 3) & 63), 6'((i * 13) & 63), "R9 stream");
      if (i % 4 == 1) wr(2'd0, 8'((i * 5) & 127), i[7:0]);
      if (i % 4 == 3) wr(2'd2, 8'((i * 29) & 255), 8'(i & 15));
      tick;
    end

    repeat (4) tick;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule